// File: doc/BRIEF.md
# GPIO Interrupt Front End with Shared Noise Filter

This block sits between up to 24 GPIO input lines and a downstream interrupt controller. Every line has three configuration bits: an interrupt enable, a mode bit that asks for detection of both edges, and a noise-filter enable. A single filter period register serves every line. A line's filter passes a new level only after the raw input has held that level for the programmed number of clock cycles. Software reaches the configuration through a small register write/read port at fixed byte offsets inside the GPIO register space.

In normal mode the block passes a line through to its interrupt output, filtered or raw as the filter enable chooses, and gated by the enable bit. The downstream controller has no both-edge sense, so in both-edge mode the block turns each change of the filtered level into a one-cycle low pulse on an output that otherwise idles high. A falling-edge detector downstream then sees every transition. Both-edge detection depends on the filter, so a both-edge line with its filter off reports no events.

Top module: `gpio_irq_frontend`

## Requirements
- R1: After reset the enable, mode and filter-enable registers read 0, the period register reads 0xFF, and every interrupt output is 0.
- R2: A write to byte offset 0x90 (enable), 0x94 (mode) or 0x98 (filter enable) stores the low 24 data bits, one per line, and reads back with the upper bits 0. A write to offset 0x9C stores the low 8 bits as the shared filter period. A read of any other offset returns 0.
- R3: A line whose enable bit is 0 drives its interrupt output to 0, whatever its input and other bits are.
- R4: With enable 1, mode 0 and filter enable 0, the output equals the raw input in the same cycle, with no register in the path.
- R5: With enable 1, mode 0 and filter enable 1, the output follows the filtered level. After the raw input changes, the filtered level takes the new value at the P-th consecutive rising clock edge on which the input differs from it, where P is the period register value.
- R6: A raw pulse that differs from the filtered level for fewer than P consecutive edges leaves the filtered level and the output unchanged.
- R7: With enable 1, mode 1 and filter enable 1, the output idles at 1 and drops to 0 for exactly one cycle, starting at the edge where the filtered level changes, for every rising and every falling filtered transition.
- R8: With enable 1, mode 1 and filter enable 0, the output stays at 1 and reports no events.
- R9: All lines use the same period. A new period value applies to every line, and a period of 0 behaves like 1, so the level changes at the first differing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr (combinational) |
| line_in | input | 24 | Raw GPIO-derived interrupt inputs |
| irq_out | output | 24 | Per-line interrupt outputs to the downstream controller |

## Verification
The assertions check the following on every cycle:
- A disabled line stays at 0.
- A both-edge line with its filter off stays at 1.
- An enable-register write lands one cycle later.
- A filtered level moves only toward the value the raw input held at the previous edge, and never while raw and filtered agreed.

The exact number of cycles before a filtered level switches can only be shown by the bench's scenarios. The same holds for the suppression of short glitches, the single-cycle width of the both-edge pulses, and the effect of reprogramming the shared period. The bench checks these with directed cases and with a long random run compared against its own cycle model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned MAX_LINES = 24;

   localparam logic [7:0] OFS_ENABLE = 8'h90;
   localparam logic [7:0] OFS_MODE   = 8'h94;
   localparam logic [7:0] OFS_FLTEN  = 8'h98;
   localparam logic [7:0] OFS_PERIOD = 8'h9C;

   localparam logic [7:0] RESET_PERIOD = 8'hFF;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NLINES   = 24,
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic [NLINES-1:0]   en_o,
   output logic [NLINES-1:0]   both_o,
   output logic [NLINES-1:0]   flten_o,
   output logic [PERIOD_W-1:0] period_o
);

   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_MD  = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_FE  = ADDR_W'(OFS_FLTEN);
   localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(OFS_PERIOD);
   localparam logic [PERIOD_W-1:0] PER_INIT = PERIOD_W'(RESET_PERIOD);

   logic [NLINES-1:0]   en_q, both_q, flten_q;
   logic [PERIOD_W-1:0] period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         both_q   <= '0;
         flten_q  <= '0;
         period_q <= PER_INIT;
      end else if (we_i) begin
         case (addr_i)
            A_EN:    en_q     <= wdata_i[NLINES-1:0];
            A_MD:    both_q   <= wdata_i[NLINES-1:0];
            A_FE:    flten_q  <= wdata_i[NLINES-1:0];
            A_PER:   period_q <= wdata_i[PERIOD_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_EN:    rdata_o = DATA_W'(en_q);
         A_MD:    rdata_o = DATA_W'(both_q);
         A_FE:    rdata_o = DATA_W'(flten_q);
         A_PER:   rdata_o = DATA_W'(period_q);
         default: rdata_o = '0;
      endcase
   end

   assign en_o     = en_q;
   assign both_o   = both_q;
   assign flten_o  = flten_q;
   assign period_o = period_q;

   // R2
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == A_EN) |=> (en_o == $past(wdata_i[NLINES-1:0])));

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                raw_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                level_o
);

   logic                level_q;
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W:0]   cnt_next;
   logic                reached;

   assign cnt_next = {1'b0, cnt_q} + (PERIOD_W+1)'(1);
   assign reached  = (cnt_next >= {1'b0, period_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         cnt_q   <= '0;
      end else if (raw_i != level_q) begin
         if (reached) begin
            level_q <= raw_i;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_next[PERIOD_W-1:0];
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign level_o = level_q;

   // R5
   level_toward_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> (level_q == $past(raw_i)));

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(raw_i) == $past(level_q)) |-> $stable(level_q));

endmodule

// File: rtl/gpio_irq_shaper.sv
module gpio_irq_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic level_i,
   input  logic en_i,
   input  logic both_i,
   input  logic flten_i,
   output logic irq_o
);

   logic level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_i;
   end

   always_comb begin
      if (!en_i)
         irq_o = 1'b0;
      else if (both_i)
         irq_o = flten_i ? ~(level_i ^ level_d) : 1'b1;
      else
         irq_o = flten_i ? level_i : raw_i;
   end

endmodule

// File: rtl/gpio_irq_frontend.sv
module gpio_irq_frontend
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NLINES   = 24,
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NLINES-1:0] line_in,
   output logic [NLINES-1:0] irq_out
);

   generate
      if (NLINES < 1 || NLINES > MAX_LINES) begin : g_bad_lines
         $error("NLINES out of range");
      end
      if (DATA_W < NLINES || DATA_W < PERIOD_W) begin : g_bad_data
         $error("DATA_W too narrow");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W cannot hold the register offsets");
      end
      if (PERIOD_W < 1 || PERIOD_W > 16) begin : g_bad_period
         $error("PERIOD_W out of range");
      end
   endgenerate

   logic [NLINES-1:0]   en, both, flten, level;
   logic [PERIOD_W-1:0] period;

   gpio_irq_regs #(
      .NLINES(NLINES), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .en_o(en), .both_o(both),
      .flten_o(flten), .period_o(period)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      gpio_irq_filter #(.PERIOD_W(PERIOD_W)) filt_i (
         .clk(clk), .rst_n(rst_n), .raw_i(line_in[i]),
         .period_i(period), .level_o(level[i])
      );

      gpio_irq_shaper shp_i (
         .clk(clk), .rst_n(rst_n), .raw_i(line_in[i]), .level_i(level[i]),
         .en_i(en[i]), .both_i(both[i]), .flten_i(flten[i]), .irq_o(irq_out[i])
      );

      // R3
      disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] |-> !irq_out[i]);

      // R8
      both_nofilter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en[i] && both[i] && !flten[i]) |-> irq_out[i]);
   end

endmodule

// File: tb/gpio_irq_frontend_tb.sv
module gpio_irq_frontend_tb_top;

   localparam int N = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] line_in = '0;
   logic [N-1:0] irq_out;

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   gpio_irq_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
      .irq_out(irq_out)
   );

   // Bench reference model of the requirements
   logic [N-1:0] m_en, m_both, m_fe, m_flt, m_fltd;
   int           m_cnt [N];
   int           m_per;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_both = '0; m_fe = '0; m_flt = '0; m_fltd = '0;
         m_per = 255;
         for (int i = 0; i < N; i++) m_cnt[i] = 0;
      end else begin
         m_fltd = m_flt;
         for (int i = 0; i < N; i++) begin
            if (line_in[i] != m_flt[i]) begin
               if (m_cnt[i] + 1 >= m_per) begin
                  m_flt[i] = line_in[i];
                  m_cnt[i] = 0;
               end else begin
                  m_cnt[i] = m_cnt[i] + 1;
               end
            end else begin
               m_cnt[i] = 0;
            end
         end
         if (reg_we) begin
            case (reg_addr)
               8'h90: m_en   = reg_wdata[N-1:0];
               8'h94: m_both = reg_wdata[N-1:0];
               8'h98: m_fe   = reg_wdata[N-1:0];
               8'h9C: m_per  = int'(reg_wdata[7:0]);
               default: ;
            endcase
         end
      end
   end

   function automatic logic [N-1:0] expect_irq(logic [N-1:0] lines);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (!m_en[i])       r[i] = 1'b0;
         else if (m_both[i]) r[i] = m_fe[i] ? ~(m_flt[i] ^ m_fltd[i]) : 1'b1;
         else                r[i] = m_fe[i] ? m_flt[i] : lines[i];
      end
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic        seen;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq_out", 32'(irq_out), 32'h0);
      rd(8'h90, d); chk("R1 enable", d, 32'h0);
      rd(8'h94, d); chk("R1 mode", d, 32'h0);
      rd(8'h98, d); chk("R1 filter", d, 32'h0);
      rd(8'h9C, d); chk("R1 period", d, 32'hFF);

      // R2 register access
      wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, d); chk("R2 enable width", d, 32'h00FF_FFFF);
      wr(8'h94, 32'h5A12_3456); rd(8'h94, d); chk("R2 mode", d, 32'h0012_3456);
      wr(8'h9C, 32'h0000_1234); rd(8'h9C, d); chk("R2 period width", d, 32'h34);
      rd(8'h00, d); chk("R2 unmapped", d, 32'h0);
      rd(8'hA0, d); chk("R2 unmapped", d, 32'h0);
      wr(8'h94, 32'h0);

      // R3 disabled lines stay low
      wr(8'h90, 32'h0);
      @(negedge clk); line_in = '1;
      idle(2); chk("R3 disabled", 32'(irq_out), 32'h0);

      // R4 raw pass-through, same cycle
      wr(8'h90, 32'hFF_FFFF);
      @(negedge clk); line_in = 24'hA5C3F0;
      #1 chk("R4 raw pattern a", 32'(irq_out), 32'h00A5_C3F0);
      @(negedge clk); line_in = 24'h1E2D4B;
      #1 chk("R4 raw pattern b", 32'(irq_out), 32'h001E_2D4B);

      // R5 filtered path, period 3
      wr(8'h9C, 32'd3);
      @(negedge clk); line_in = '0;
      idle(6);
      wr(8'h98, 32'hFF_FFFF);
      @(negedge clk); line_in[0] = 1'b1;
      idle(2); chk("R5 before third edge", 32'(irq_out[0]), 32'h0);
      idle(1); chk("R5 at third edge", 32'(irq_out[0]), 32'h1);

      // R6 short glitch
      line_in[1] = 1'b1;
      seen = 1'b0;
      idle(2);
      seen = seen | irq_out[1];
      line_in[1] = 1'b0;
      for (int k = 0; k < 5; k++) begin
         idle(1);
         seen = seen | irq_out[1];
      end
      chk("R6 glitch suppressed", 32'(seen), 32'h0);

      // R7 both-edge pulses on line 2
      wr(8'h94, 32'h4);
      @(negedge clk);
      chk("R7 idle high", 32'(irq_out[2]), 32'h1);
      line_in[2] = 1'b1;
      idle(2); chk("R7 rise before", 32'(irq_out[2]), 32'h1);
      idle(1); chk("R7 rise pulse", 32'(irq_out[2]), 32'h0);
      idle(1); chk("R7 rise one cycle", 32'(irq_out[2]), 32'h1);
      line_in[2] = 1'b0;
      idle(2); chk("R7 fall before", 32'(irq_out[2]), 32'h1);
      idle(1); chk("R7 fall pulse", 32'(irq_out[2]), 32'h0);
      idle(1); chk("R7 fall one cycle", 32'(irq_out[2]), 32'h1);

      // R8 both-edge without filter: no events on line 3
      wr(8'h94, 32'hC);
      wr(8'h98, 32'hFF_FFF7);
      seen = 1'b1;
      for (int k = 0; k < 8; k++) begin
         line_in[3] = k[1];
         idle(1);
         seen = seen & irq_out[3];
      end
      chk("R8 stays high", 32'(seen), 32'h1);

      // R9 shared period: new value 5 on line 4, then 0 on line 5
      wr(8'h9C, 32'd5);
      @(negedge clk); line_in[4] = 1'b1;
      idle(4); chk("R9 period 5 before", 32'(irq_out[4]), 32'h0);
      idle(1); chk("R9 period 5 at", 32'(irq_out[4]), 32'h1);
      wr(8'h9C, 32'd0);
      @(negedge clk); line_in[5] = 1'b1;
      #1 chk("R9 period 0 before edge", 32'(irq_out[5]), 32'h0);
      idle(1); chk("R9 period 0 first edge", 32'(irq_out[5]), 32'h1);

      // Random run against the model (R4 R5 R6 R7 R8 R9)
      wr(8'h9C, 32'd2);
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         chk("R4 R5 R7 R8 random", 32'(irq_out), 32'(expect_irq(line_in)));
         reg_we = 1'b0;
         if ($urandom_range(0, 19) == 0) begin
            reg_we = 1'b1;
            case ($urandom_range(0, 3))
               0: begin reg_addr = 8'h90; reg_wdata = $urandom; end
               1: begin reg_addr = 8'h94; reg_wdata = $urandom; end
               2: begin reg_addr = 8'h98; reg_wdata = $urandom; end
               default: begin reg_addr = 8'h9C; reg_wdata = 32'($urandom_range(0, 6)); end
            endcase
         end
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 3) == 0) line_in[i] = ~line_in[i];
      end
      @(negedge clk);
      reg_we = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule